// File: doc/BRIEF.md
# Sector-Erase Accumulation Window

This block sits behind a flash command decoder. Once the decoder has accepted a complete sector-erase unlock sequence, the block records the addressed sector in an eight-bit selection mask. It then opens a collection window. Each further write cycle that carries the sector-erase command adds one more sector to the mask and restarts the window. When the window runs out with no write activity, the block issues a one-cycle start pulse to the erase engine, together with the mask of sectors to erase. The mask is held until the engine reports completion.

The window length is given in clock cycles by a parameter. The window timer restarts on the falling edge of each write strobe, and it does not run while the strobe is low. The timer therefore expires a full window after the rising edge of the last write. A status output reads low only while the window is open. A write cycle inside the window that carries any data other than the sector command or the suspend command cancels the queue. The block then pulses an abort output, clears the mask and returns to idle. Write cycles that arrive after the window has closed leave the mask alone.

The strobe edges reach the block as single-cycle pulses that have already been synchronised to its clock. The sector index is taken from the top bits of the write address.

Top module: `sector_erase_window`

## Requirements
- R1: After reset, win_status is 1, erase_mask is 0, and erase_start and abort are both 0.
- R2: A cmd_accept pulse in idle sets the mask bit whose index is the top three bits of wr_addr. From the next cycle on, win_status is 0.
- R3: While the window is open, a strobe_rise with wr_data equal to 8'h30 sets the mask bit of the sector in wr_addr. Sectors can be selected in any order. Selecting a sector that is already set changes nothing, and all eight sectors can be selected.
- R4: With no strobe activity after the strobe_rise or cmd_accept of edge E, erase_start is high for exactly one cycle, in the cycle after edge E+WIN_CYC. erase_mask then holds the accumulated selection.
- R5: A strobe_fall restarts the window timer. The window cannot expire while the strobe is low, that is, between a strobe_fall and the next strobe_rise.
- R6: win_status is 0 exactly while the window is open. It is 1 in idle and from the start pulse until erase_done.
- R7: While the window is open, a strobe_rise whose wr_data is neither 8'h30 nor 8'hB0 pulses abort for one cycle, clears erase_mask to 0 and returns the block to idle (win_status 1). No erase_start follows.
- R8: While the window is open, a strobe_rise with wr_data 8'hB0 leaves the mask unchanged and does not abort, but it does restart the window.
- R9: After the window has closed, sector write cycles do not change erase_mask. An erase_done pulse clears the mask and returns the block to idle.
- R10: In idle, strobe pulses without cmd_accept leave erase_mask at 0 and win_status at 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_accept | input | 1 | Decoder accepted the full sector-erase sequence; wr_addr holds the first sector |
| strobe_fall | input | 1 | Single-cycle pulse on the write strobe falling edge |
| strobe_rise | input | 1 | Single-cycle pulse on the write strobe rising edge; wr_addr and wr_data are valid |
| wr_addr | input | ADDR_W | Write address; top SECT_W bits select the sector |
| wr_data | input | 8 | Write data (command byte) |
| erase_done | input | 1 | Erase engine finished |
| erase_start | output | 1 | One-cycle pulse that starts the erase |
| erase_mask | output | 2**SECT_W | Selected sectors |
| abort | output | 1 | One-cycle pulse when an invalid command cancels the queue |
| win_status | output | 1 | Low while the collection window is open |

## Verification
The bench targets the exact expiry cycle after a retriggered window. A timer that counted from the wrong edge, or that kept running while the strobe was held low, would start the erase early, and the scoreboard would catch the off-cycle start pulse. It checks that repeated and reverse-order selections build the right mask, and that a full eight-sector mask comes out intact. It also checks that the suspend byte neither aborts nor alters the mask, while any other byte aborts with a cleared mask and no later start. Finally, it checks that late sector writes after expiry and strobe traffic in idle leave the mask untouched, which a design that kept loading after the window closed would fail.

// File: rtl/sewin_pkg.sv
package sewin_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_WINDOW = 2'd1,
    ST_ERASE  = 2'd2
  } win_state_e;

  localparam logic [7:0] CMD_SECTOR  = 8'h30;
  localparam logic [7:0] CMD_SUSPEND = 8'hB0;
endpackage

// File: rtl/sewin_sector_decode.sv
module sewin_sector_decode #(
  parameter int ADDR_W = 19,
  parameter int SECT_W = 3,
  localparam int NSECT = 1 << SECT_W
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [NSECT-1:0]  onehot
);
  logic [SECT_W-1:0] idx;
  assign idx = addr[ADDR_W-1 -: SECT_W];

  for (genvar i = 0; i < NSECT; i++) begin : g_bit
    assign onehot[i] = (idx == SECT_W'(i));
  end
endmodule

// File: rtl/sewin_timer.sv
module sewin_timer #(
  parameter int WIN_CYC = 40,
  localparam int CNT_W = (WIN_CYC < 2) ? 1 : $clog2(WIN_CYC)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic restart,
  input  logic hold,
  output logic expire
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WIN_CYC - 1);

  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic             cnt_en;

  assign expire = run && !restart && !hold && (cnt_q == LAST);
  assign cnt_en = 1'b1;

  always_comb begin
    cnt_n = cnt_q;
    if (!run || restart || hold) begin
      cnt_n = '0;
    end else if (cnt_q != LAST) begin
      cnt_n = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_n;
    end
  end
endmodule

// File: rtl/sector_erase_window.sv
module sector_erase_window
  import sewin_pkg::*;
#(
  parameter int ADDR_W  = 19,
  parameter int SECT_W  = 3,
  parameter int WIN_CYC = 40,
  localparam int NSECT  = 1 << SECT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_accept,
  input  logic              strobe_fall,
  input  logic              strobe_rise,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              erase_done,
  output logic              erase_start,
  output logic [NSECT-1:0]  erase_mask,
  output logic              abort,
  output logic              win_status
);
  win_state_e       state_q, state_n;
  logic [NSECT-1:0] mask_q, mask_n;
  logic             start_q, start_n;
  logic             abort_q, abort_n;
  logic             low_q, low_n;
  logic [NSECT-1:0] sel;
  logic             in_window;
  logic             expire;

  sewin_sector_decode #(.ADDR_W(ADDR_W), .SECT_W(SECT_W)) u_dec (
    .addr   (wr_addr),
    .onehot (sel)
  );

  assign in_window = (state_q == ST_WINDOW);

  sewin_timer #(.WIN_CYC(WIN_CYC)) u_tmr (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (in_window),
    .restart (strobe_fall || strobe_rise),
    .hold    (low_q),
    .expire  (expire)
  );

  always_comb begin
    low_n = low_q;
    if (strobe_fall) begin
      low_n = 1'b1;
    end
    if (strobe_rise || cmd_accept) begin
      low_n = 1'b0;
    end
  end

  always_comb begin
    state_n = state_q;
    mask_n  = mask_q;
    start_n = 1'b0;
    abort_n = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (cmd_accept) begin
          mask_n  = sel;
          state_n = ST_WINDOW;
        end
      end
      ST_WINDOW: begin
        if (strobe_rise) begin
          if (wr_data == CMD_SECTOR) begin
            mask_n = mask_q | sel;
          end else if (wr_data != CMD_SUSPEND) begin
            mask_n  = '0;
            abort_n = 1'b1;
            state_n = ST_IDLE;
          end
        end else if (expire) begin
          start_n = 1'b1;
          state_n = ST_ERASE;
        end
      end
      ST_ERASE: begin
        if (erase_done) begin
          mask_n  = '0;
          state_n = ST_IDLE;
        end
      end
      default: begin
        state_n = ST_IDLE;
        mask_n  = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      mask_q  <= '0;
      start_q <= 1'b0;
      abort_q <= 1'b0;
      low_q   <= 1'b0;
    end else begin
      state_q <= state_n;
      mask_q  <= mask_n;
      start_q <= start_n;
      abort_q <= abort_n;
      low_q   <= low_n;
    end
  end

  assign erase_start = start_q;
  assign erase_mask  = mask_q;
  assign abort       = abort_q;
  assign win_status  = !in_window;
endmodule

// File: rtl/sector_erase_window_chk.sv
module sector_erase_window_chk #(
  parameter int NSECT = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_accept,
  input logic             strobe_fall,
  input logic             erase_done,
  input logic             erase_start,
  input logic [NSECT-1:0] erase_mask,
  input logic             abort,
  input logic             win_status
);
  a_r4_start_single: assert property (@(posedge clk) disable iff (!rst_n)
    erase_start |=> !erase_start);

  a_r4_start_with_mask: assert property (@(posedge clk) disable iff (!rst_n)
    erase_start |-> (erase_mask != '0) && win_status);

  a_r2_accept_opens: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_accept && win_status && erase_mask == '0) |=> !win_status);

  a_r5_fall_blocks_start: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_fall |=> !erase_start);

  a_r7_abort_clears: assert property (@(posedge clk) disable iff (!rst_n)
    abort |-> (erase_mask == '0) && win_status && !erase_start);

  a_r9_mask_held: assert property (@(posedge clk) disable iff (!rst_n)
    (erase_mask != '0 && win_status && !erase_done) |=> $stable(erase_mask));
endmodule

bind sector_erase_window sector_erase_window_chk #(.NSECT(NSECT)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cmd_accept  (cmd_accept),
  .strobe_fall (strobe_fall),
  .erase_done  (erase_done),
  .erase_start (erase_start),
  .erase_mask  (erase_mask),
  .abort       (abort),
  .win_status  (win_status)
);

// File: tb/sector_erase_window_tb_top.sv
module sector_erase_window_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 19;
  localparam int WIN = 20;

  logic clk, rst_n;
  logic cmd_accept, strobe_fall, strobe_rise, erase_done;
  logic [ADDR_W-1:0] wr_addr;
  logic [7:0] wr_data;
  logic erase_start, abort, win_status;
  logic [7:0] erase_mask;

  int checks, errors, cyc;
  bit done_flag;

  typedef struct packed {
    logic        is_abort;
    logic [7:0]  mask;
    logic [31:0] at;
  } ev_t;
  ev_t expq[$];

  sector_erase_window #(.ADDR_W(ADDR_W), .SECT_W(3), .WIN_CYC(WIN)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_accept(cmd_accept),
    .strobe_fall(strobe_fall), .strobe_rise(strobe_rise),
    .wr_addr(wr_addr), .wr_data(wr_data), .erase_done(erase_done),
    .erase_start(erase_start), .erase_mask(erase_mask),
    .abort(abort), .win_status(win_status)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  function automatic logic [ADDR_W-1:0] saddr(input int s);
    return {s[2:0], 16'h1234};
  endfunction

  // monitor: pops expected events as the design produces them
  always @(negedge clk) begin
    if (rst_n && (erase_start || abort)) begin
      if (expq.size() == 0) begin
        checks++; errors++;
        $display("FAIL R4/R7 unexpected event start=%0b abort=%0b cycle=%0d", erase_start, abort, cyc);
      end else begin
        ev_t e;
        e = expq.pop_front();
        check(e.is_abort ? "R7 abort kind" : "R4 start kind", {30'd0, abort, erase_start},
              e.is_abort ? 32'd2 : 32'd1);
        check(e.is_abort ? "R7 abort mask" : "R4 start mask", {24'd0, erase_mask}, {24'd0, e.mask});
        check(e.is_abort ? "R7 abort cycle" : "R4 start cycle", cyc, e.at);
      end
    end
  end

  task automatic push_ev(input logic ab, input logic [7:0] m, input int at);
    ev_t e;
    e.is_abort = ab; e.mask = m; e.at = at;
    expq.push_back(e);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // returns the posedge number that sampled the pulse
  task automatic accept(input int s, output int edge_no);
    @(negedge clk);
    cmd_accept = 1'b1; wr_addr = saddr(s); wr_data = 8'h30;
    edge_no = cyc + 1;
    @(negedge clk);
    cmd_accept = 1'b0;
  endtask

  task automatic fall_only();
    @(negedge clk);
    strobe_fall = 1'b1;
    @(negedge clk);
    strobe_fall = 1'b0;
  endtask

  task automatic rise_only(input int s, input logic [7:0] d, output int edge_no);
    @(negedge clk);
    strobe_rise = 1'b1; wr_addr = saddr(s); wr_data = d;
    edge_no = cyc + 1;
    @(negedge clk);
    strobe_rise = 1'b0;
  endtask

  task automatic wcycle(input int s, input logic [7:0] d, output int edge_no);
    fall_only();
    strobe_rise = 1'b1; wr_addr = saddr(s); wr_data = d;
    edge_no = cyc + 1;
    @(negedge clk);
    strobe_rise = 1'b0;
  endtask

  task automatic finish_erase();
    @(negedge clk);
    erase_done = 1'b1;
    @(negedge clk);
    erase_done = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done_flag) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int e;
    cyc = 0; checks = 0; errors = 0;
    cmd_accept = 0; strobe_fall = 0; strobe_rise = 0; erase_done = 0;
    wr_addr = '0; wr_data = '0;
    rst_n = 1'b0;
    idle(3);
    rst_n = 1'b1;
    idle(2);
    // R1 reset state
    check("R1 win_status", win_status, 1);
    check("R1 erase_mask", erase_mask, 0);
    check("R1 erase_start", erase_start, 0);
    check("R1 abort", abort, 0);

    // R10 idle strobes ignored
    wcycle(5, 8'h30, e);
    idle(3);
    check("R10 mask idle", erase_mask, 0);
    check("R10 status idle", win_status, 1);

    // R2 / R3 / R4 / R6: accumulate with repeat and gaps
    accept(2, e);
    check("R2 mask after accept", erase_mask, 8'h04);
    check("R2 status low", win_status, 0);
    idle(5); wcycle(6, 8'h30, e);
    idle(5); wcycle(0, 8'h30, e);
    idle(5); wcycle(6, 8'h30, e);
    check("R3 repeat idempotent", erase_mask, 8'h45);
    idle(5); wcycle(7, 8'h30, e);
    push_ev(1'b0, 8'hC5, e + WIN);
    while (cyc < e + WIN - 1) @(negedge clk);
    check("R6 status low before expiry", win_status, 0);
    @(negedge clk);
    check("R6 status high at start", win_status, 1);
    // R9 late cycle ignored
    idle(3); wcycle(1, 8'h30, e);
    idle(2);
    check("R9 late cycle not loaded", erase_mask, 8'hC5);
    finish_erase();
    check("R9 mask cleared by done", erase_mask, 0);
    check("R9 idle after done", win_status, 1);

    // R5 strobe held low blocks expiry
    accept(3, e);
    fall_only();
    idle(3 * WIN);
    check("R5 window open while low", win_status, 0);
    rise_only(4, 8'h30, e);
    push_ev(1'b0, 8'h18, e + WIN);
    idle(WIN + 3);
    finish_erase();

    // R7 abort
    accept(1, e);
    idle(2); wcycle(3, 8'h30, e);
    idle(2); wcycle(4, 8'hA0, e);
    push_ev(1'b1, 8'h00, e);
    idle(1);
    check("R7 mask cleared", erase_mask, 0);
    check("R7 status idle", win_status, 1);
    idle(2 * WIN);

    // R8 suspend byte ignored but retriggers
    accept(0, e);
    idle(4); wcycle(7, 8'hB0, e);
    check("R8 mask unchanged", erase_mask, 8'h01);
    check("R8 still open", win_status, 0);
    push_ev(1'b0, 8'h01, e + WIN);
    idle(WIN + 3);
    finish_erase();

    // R3 all eight in reverse order
    accept(7, e);
    for (int s = 6; s >= 0; s--) begin
      idle(2); wcycle(s, 8'h30, e);
    end
    check("R3 full mask", erase_mask, 8'hFF);
    push_ev(1'b0, 8'hFF, e + WIN);
    idle(WIN + 3);
    finish_erase();
    idle(3);

    checks++;
    if (expq.size() != 0) begin
      errors++;
      $display("FAIL R4 missing events actual=%0d expected=0", expq.size());
    end
    done_flag = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule